// File: doc/BRIEF.md
# Nine-bit three-wire command serializer

This block sends configuration traffic to a display controller over a three-wire serial port with chip select, serial clock and one data line. Bytes arrive on a valid/ready stream, with a flag that closes a message. A message is one command byte followed by any number of parameter bytes. Each byte leaves as a 9-bit word. The extra leading bit tells the panel what kind of byte follows: 0 for the command that opens a message and 1 for every parameter after it.

Chip select stays low for the whole message, so a command and its parameters form one transfer. The serial clock idles high. Data changes on the falling edge and the panel samples it on the rising edge. The half-period of the serial clock, counted in system clocks, is a parameter. A typical message is the bank switch: command 0xFF, parameters 0x77, 0x01, 0x00, 0x00 and then a bank code (0x10, 0x11, 0x13, or 0x00 to leave the extended set). It goes out as words 0x0FF, 0x177, 0x101, 0x100, 0x100, 0x1xx.

Top module: `panel_cfg_tx`

## Requirements
- R1: Every word on the line is 9 bits, sent most significant bit first. Bits 7..0 carry the input byte, and each chip-select assertion holds a whole number of words.
- R2: Bit 8 of a word is 0 for the first byte of a message and 1 for every later byte of that message. A message ends with the byte accepted with last_i high.
- R3: sck_o is high whenever cs_no is high. sdo_o holds steady across each rising edge of sck_o.
- R4: cs_no stays low from the first word of a message to the last word, also while the block waits for a late parameter byte. While waiting it holds sck_o high and ready_o high.
- R5: cs_no goes low at least HALF_DIV system clocks before the first falling edge of sck_o.
- R6: cs_no stays high for at least 2*HALF_DIV system clocks between messages.
- R7: ready_o is low while a word is shifting. A byte is taken only on a cycle where valid_i and ready_o are both high, and a byte offered while ready_o is low is neither lost nor sent twice.
- R8: After reset, cs_no is high, sck_o is high and ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Command or parameter byte |
| valid_i | input | 1 | data_i holds a byte |
| last_i | input | 1 | This byte closes the message |
| ready_o | output | 1 | Block can take a byte this cycle |
| cs_no | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data |

## Verification
Two situations are hard to reach from the ports. The first is a message whose next parameter arrives late. The bench leaves the block parked between words with chip select low for tens of cycles, then checks that the line holds, that no clock edge is emitted and that the next word still carries the parameter flag. The second is a byte offered while a word is still shifting. The bench raises valid_i at once after an accept and holds it through the whole word. It then confirms that the wait covered the full word time and that the byte appears on the line exactly once.

// File: rtl/panel_cfg_pkg.sv
package panel_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_WAIT,
    ST_HOLD,
    ST_GAP
  } tx_state_e;
endpackage

// File: rtl/panel_cfg_tick.sv
module panel_cfg_tick #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/panel_cfg_shreg.sv
module panel_cfg_shreg #(
  parameter int unsigned WORD_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              shift_i,
  output logic              msb_o
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else if (load_i) sr_q <= word_i;
    else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], 1'b0};
  end

  assign msb_o = sr_q[WORD_W-1];
endmodule

// File: rtl/panel_cfg_tx.sv
module panel_cfg_tx
  import panel_cfg_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned HALF_DIV   = 2,
  parameter int unsigned GAP_HALVES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              last_i,
  output logic              ready_o,
  output logic              cs_no,
  output logic              sck_o,
  output logic              sdo_o
);
  localparam int unsigned WORD_W = DATA_W + 1;
  localparam int unsigned BIT_W  = $clog2(WORD_W);
  localparam int unsigned GAP_W  = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(GAP_HALVES - 1);

  tx_state_e         state_q;
  logic              cs_q, sck_q, last_q;
  logic [BIT_W-1:0]  bit_q;
  logic [GAP_W-1:0]  gap_q;
  logic              run, tick, accept, shift;
  logic [WORD_W-1:0] load_word;

  assign ready_o   = (state_q == ST_IDLE) || (state_q == ST_WAIT);
  assign accept    = valid_i && ready_o;
  assign run       = state_q inside {ST_SETUP, ST_LOW, ST_HIGH, ST_HOLD, ST_GAP};
  // flag bit: parameter when continuing a message
  assign load_word = {state_q == ST_WAIT, data_i};
  assign shift     = (state_q == ST_HIGH) && tick && (bit_q != LAST_BIT);

  panel_cfg_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  panel_cfg_shreg #(.WORD_W(WORD_W)) u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .word_i (load_word),
    .shift_i(shift),
    .msb_o  (sdo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b1;
      sck_q   <= 1'b1;
      last_q  <= 1'b0;
      bit_q   <= '0;
      gap_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          last_q  <= last_i;
          cs_q    <= 1'b0;
          state_q <= ST_SETUP;
        end
        ST_SETUP: if (tick) begin
          sck_q   <= 1'b0;
          bit_q   <= '0;
          state_q <= ST_LOW;
        end
        ST_LOW: if (tick) begin
          sck_q   <= 1'b1;
          state_q <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          if (bit_q == LAST_BIT) begin
            state_q <= last_q ? ST_HOLD : ST_WAIT;
          end else begin
            bit_q   <= bit_q + 1'b1;
            sck_q   <= 1'b0;
            state_q <= ST_LOW;
          end
        end
        ST_WAIT: if (accept) begin
          last_q  <= last_i;
          bit_q   <= '0;
          sck_q   <= 1'b0;
          state_q <= ST_LOW;
        end
        ST_HOLD: if (tick) begin
          cs_q    <= 1'b1;
          gap_q   <= '0;
          state_q <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          if (gap_q == GAP_MAX) state_q <= ST_IDLE;
          else gap_q <= gap_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no = cs_q;
  assign sck_o = sck_q;

  a_r3_sck_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sck_o);
  a_r3_sdo_steady_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> $stable(sdo_o));
  a_r7_not_ready_in_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !sck_o) |-> !ready_o);
  a_r5_no_fall_with_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |=> $stable(sck_o));
  a_r6_gap_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |=> cs_no);
  a_r4_cs_rise_after_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> $past(sck_o));
endmodule

// File: tb/panel_cfg_tx_tb_top.sv
module panel_cfg_tx_tb_top;
  localparam int HALF = 2;
  localparam int NVEC = 17;
  // {last, byte}
  localparam logic [8:0] VEC [NVEC] = '{
    9'h0FF, 9'h077, 9'h001, 9'h000, 9'h000, 9'h110,
    9'h0C0, 9'h03B, 9'h100,
    9'h111,
    9'h0FF, 9'h077, 9'h001, 9'h000, 9'h000, 9'h100,
    9'h129
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] data = '0;
  logic valid = 1'b0, last = 1'b0;
  logic ready_o, cs_no, sck_o, sdo_o;

  always #2.5 clk = ~clk;

  panel_cfg_tx #(.DATA_W(8), .HALF_DIV(HALF), .GAP_HALVES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid), .last_i(last),
    .ready_o(ready_o), .cs_no(cs_no), .sck_o(sck_o), .sdo_o(sdo_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  logic [8:0] rx_words [64];
  logic [8:0] exp_words [64];
  int msg_len [16];
  int exp_len [16];
  int rx_cnt = 0, exp_cnt = 0, msg_cnt = 0, exp_msg = 0, msg_start = 0, exp_start = 0;
  bit first_q = 1'b1;

  // line monitor
  logic cs_p = 1'b1, sck_p = 1'b1;
  logic [8:0] sh = '0;
  int bits = 0, lo_cnt = 0, hi_cnt = 1000;
  bit pend = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (cs_no && !cs_p) begin
      chk(bits % 9 == 0, "R1 whole words", bits, 9 * (bits / 9));
      msg_len[msg_cnt] = rx_cnt - msg_start;
      msg_cnt++;
      hi_cnt = 0;
    end
    if (cs_no) begin
      hi_cnt++;
      chk(sck_o, "R3 sck idle high", sck_o, 1);
    end
    if (!cs_no && cs_p) begin
      chk(hi_cnt >= 2 * HALF, "R6 cs gap", hi_cnt, 2 * HALF);
      lo_cnt = 0; pend = 1'b1; bits = 0; msg_start = rx_cnt;
    end
    if (!cs_no) lo_cnt++;
    if (!cs_no && !sck_o && sck_p && pend) begin
      chk(lo_cnt > HALF, "R5 cs setup", lo_cnt - 1, HALF);
      pend = 1'b0;
    end
    if (!cs_no && sck_o && !sck_p) begin
      sh = {sh[7:0], sdo_o};
      bits++;
      if (bits % 9 == 0) begin
        rx_words[rx_cnt] = sh;
        rx_cnt++;
      end
    end
    cs_p = cs_no; sck_p = sck_o;
  end

  int wait_cyc;
  task automatic send(input logic [7:0] b, input bit l);
    @(negedge clk);
    valid = 1'b1; data = b; last = l;
    wait_cyc = 0;
    while (!ready_o) begin
      @(negedge clk);
      wait_cyc++;
    end
    @(posedge clk);
    #1 valid = 1'b0;
    exp_words[exp_cnt] = {!first_q, b};
    exp_cnt++;
    if (l) begin
      exp_len[exp_msg] = exp_cnt - exp_start;
      exp_msg++;
      exp_start = exp_cnt;
    end
    first_q = l;
  endtask

  task automatic drain();
    repeat (40 * HALF) @(negedge clk);
  endtask

  task automatic compare_all();
    chk(rx_cnt == exp_cnt, "R1 word count", rx_cnt, exp_cnt);
    for (int i = 0; i < exp_cnt && i < rx_cnt; i++) begin
      chk(rx_words[i][7:0] == exp_words[i][7:0], "R1 payload", rx_words[i], exp_words[i]);
      chk(rx_words[i][8] == exp_words[i][8], "R2 flag bit", rx_words[i], exp_words[i]);
    end
    chk(msg_cnt == exp_msg, "R4 message count", msg_cnt, exp_msg);
    for (int i = 0; i < exp_msg && i < msg_cnt; i++)
      chk(msg_len[i] == exp_len[i], "R4 words per select", msg_len[i], exp_len[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8
    chk(cs_no, "R8 reset cs", cs_no, 1);
    chk(sck_o, "R8 reset sck", sck_o, 1);
    chk(ready_o, "R8 reset ready", ready_o, 1);

    // R7 no valid, no transfer
    repeat (20) @(negedge clk);
    chk(cs_no && rx_cnt == 0, "R7 idle without valid", rx_cnt, 0);

    // table walk
    for (int i = 0; i < NVEC; i++) send(VEC[i][7:0], VEC[i][8]);
    drain();
    compare_all();

    // R4 stalled parameter
    send(8'hFF, 1'b0);
    repeat (25 * HALF) @(negedge clk);
    begin
      bit ok = 1'b1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (cs_no || !sck_o || !ready_o) ok = 1'b0;
      end
      chk(ok, "R4 hold during stall", ok, 1);
    end
    send(8'h42, 1'b1);
    drain();
    compare_all();

    // R7 byte offered during shifting
    send(8'hC0, 1'b0);
    send(8'h5A, 1'b1);
    chk(wait_cyc >= 18 * HALF, "R7 ready low in word", wait_cyc, 18 * HALF);
    drain();
    compare_all();

    // R6 back-to-back single-byte messages
    send(8'h11, 1'b1);
    send(8'h29, 1'b1);
    send(8'h28, 1'b1);
    drain();
    compare_all();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule